// File: doc/BRIEF.md
# Chainable Performance Counter Bank

This block is a set of 32-bit event counters and one free-running 64-bit cycle counter. Software configures and reads it through a simple register port. Each event counter has its own event-select code, enable bit and sticky overflow flag. The block takes a vector of single-cycle event pulses and a clock-tick strobe. It raises one interrupt line when any overflow flag that is unmasked is set.

Any adjacent pair of counters, made of an even counter and the odd counter above it, can act as one 64-bit counter. To do this, software programs the odd counter with the reserved link code 0x1E. The odd counter then advances each time its even partner rolls over, and software reads the pair as {odd, even}. The cycle counter is always 64 bits wide. Software can make it behave as a 32-bit counter by preloading its upper word with all ones, so that it overflows when the lower word rolls over.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. Register map (word addresses on `addr`): 0x00 control (bit 0 is the global enable); 0x01 counter enables (bit i is counter i, bit 31 is the cycle counter); 0x02 overflow flags (same bit layout, write one to clear); 0x03 interrupt mask (same layout); 0x04 cycle counter low word; 0x05 cycle counter high word; 0x08+i value of counter i; 0x10+i event code of counter i (bits 7:0). `rdata` shows the register at `addr` combinationally.
- R2: Counter i increments by one on each rising clock edge at which the global enable is set, its enable bit is set, its code c is below NEVT and `evt_in[c]` is high. Any other code below 0x1E, and any code above it, never counts.
- R3: An odd counter whose code is 0x1E increments once on each edge at which its even partner wraps from 0xFFFFFFFF to 0, provided the odd counter is enabled. The pair then forms the 64-bit value {odd, even}.
- R4: A linked odd counter whose enable bit is clear ignores the wraps of its partner and holds its value.
- R5: A linked odd counter never advances when its even partner does not count. This covers an even partner that is disabled, one that has an absent event code, and one that has itself been given code 0x1E, which counts nothing on an even counter.
- R6: The 64-bit cycle counter increments on each edge at which `cyc_tick`, the global enable and enable bit 31 are all high. The carry from the low word passes into the high word.
- R7: Overflow flag 31 is set when the 64-bit cycle counter wraps to zero. If the high word is preloaded with 0xFFFFFFFF, this happens when the low word rolls over.
- R8: The overflow flag of a counter is set on the edge at which that counter wraps. A flag stays set until software writes a one to its bit. A new wrap in the same cycle as the clear leaves the flag set.
- R9: `irq` is high exactly when some overflow flag is set whose mask bit is also set.
- R10: While the global enable is low, no counter changes except through a register write, and every register stays readable and writable.
- R11: A register write to a counter in the same cycle as an increment of that counter wins. The written value is stored, and that cycle produces no wrap and no carry into a linked partner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register word address, used for both write and read |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Read data for `addr` |
| evt_in | input | NEVT | Single-cycle event pulses |
| cyc_tick | input | 1 | Cycle-counter tick |
| irq | output | 1 | Overflow interrupt |

## Verification
A bad chain carry shows up in the upper word of a linked pair on the first read after the even half rolls over. Because every increment stores at once, a count that drifts by a single event appears at the very next read. A flag that is set or cleared wrongly reaches `irq` within the same cycle once its mask bit is set. The bench therefore checks counter values and `irq` right after each stimulus, before any later traffic can hide the fault.

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
  parameter int NCNT = 4,
  parameter int NEVT = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  input  logic [NEVT-1:0] evt_in,
  input  logic            cyc_tick,
  output logic            irq
);
  localparam logic [7:0] LINK = 8'h1E;
  localparam logic [7:0] A_CTRL = 8'h00, A_EN = 8'h01, A_OVF = 8'h02, A_MASK = 8'h03;
  localparam logic [7:0] A_CYLO = 8'h04, A_CYHI = 8'h05, A_CNT = 8'h08, A_SEL = 8'h10;
  localparam int EW = $clog2(NEVT);
  localparam logic [31:0] VALID = {1'b1, {(31-NCNT){1'b0}}, {NCNT{1'b1}}};

  logic                  gen_en;
  logic [31:0]           en_q, ovf_q, mask_q, ovf_set;
  logic [NCNT-1:0][31:0] cnt_q;
  logic [NCNT-1:0][7:0]  sel_q;
  logic [63:0]           cyc_q;
  logic [NCNT-1:0]       inc, wrap, cnt_wr;
  logic                  cyc_inc, cyc_wr_lo, cyc_wr_hi, cyc_wrap;

  function automatic logic hit(input logic [7:0] code, input logic [NEVT-1:0] ev);
    return (int'(code) < NEVT) && code != LINK && ev[code[EW-1:0]];
  endfunction

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    logic raw;
    if (i % 2 == 1) begin : g_odd
      assign raw = (sel_q[i] == LINK) ? wrap[i-1] : hit(sel_q[i], evt_in);
    end else begin : g_even
      assign raw = hit(sel_q[i], evt_in);
    end
    assign cnt_wr[i] = wr_en && addr == A_CNT + 8'(i);
    assign inc[i]    = gen_en & en_q[i] & raw;
    assign wrap[i]   = inc[i] & (&cnt_q[i]) & ~cnt_wr[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[i] <= '0;
        sel_q[i] <= '0;
      end else begin
        if (cnt_wr[i]) cnt_q[i] <= wdata;
        else if (inc[i]) cnt_q[i] <= cnt_q[i] + 32'd1;
        if (wr_en && addr == A_SEL + 8'(i)) sel_q[i] <= wdata[7:0];
      end
    end
  end

  assign cyc_wr_lo = wr_en && addr == A_CYLO;
  assign cyc_wr_hi = wr_en && addr == A_CYHI;
  assign cyc_inc   = gen_en & en_q[31] & cyc_tick;
  assign cyc_wrap  = cyc_inc & (&cyc_q) & ~cyc_wr_lo & ~cyc_wr_hi;

  always_comb begin
    ovf_set = '0;
    ovf_set[NCNT-1:0] = wrap;
    ovf_set[31] = cyc_wrap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_en <= 1'b0;
      en_q   <= '0;
      ovf_q  <= '0;
      mask_q <= '0;
      cyc_q  <= '0;
    end else begin
      if (wr_en && addr == A_CTRL) gen_en <= wdata[0];
      if (wr_en && addr == A_EN)   en_q   <= wdata & VALID;
      if (wr_en && addr == A_MASK) mask_q <= wdata & VALID;
      if (wr_en && addr == A_OVF)  ovf_q  <= (ovf_q & ~wdata) | ovf_set;
      else                         ovf_q  <= ovf_q | ovf_set;
      if (cyc_wr_lo || cyc_wr_hi) begin
        if (cyc_wr_lo) cyc_q[31:0]  <= wdata;
        if (cyc_wr_hi) cyc_q[63:32] <= wdata;
      end else if (cyc_inc) begin
        cyc_q <= cyc_q + 64'd1;
      end
    end
  end

  assign irq = |(ovf_q & mask_q);

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata = {31'b0, gen_en};
      A_EN:    rdata = en_q;
      A_OVF:   rdata = ovf_q;
      A_MASK:  rdata = mask_q;
      A_CYLO:  rdata = cyc_q[31:0];
      A_CYHI:  rdata = cyc_q[63:32];
      default: begin
        for (int i = 0; i < NCNT; i++) begin
          if (addr == A_CNT + 8'(i)) rdata = cnt_q[i];
          if (addr == A_SEL + 8'(i)) rdata = {24'b0, sel_q[i]};
        end
      end
    endcase
  end
endmodule

// File: rtl/perf_counter_bank_chk.sv
module perf_counter_bank_chk #(
  parameter int NCNT = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [7:0]            addr,
  input logic [31:0]           wdata,
  input logic                  gen_en,
  input logic [31:0]           en_q,
  input logic [31:0]           ovf_q,
  input logic [NCNT-1:0][31:0] cnt_q,
  input logic [NCNT-1:0][7:0]  sel_q,
  input logic [63:0]           cyc_q,
  input logic [NCNT-1:0]       inc,
  input logic                  cyc_inc
);
  logic wr_c0, wr_c1, wr_cyc;
  assign wr_c0  = wr_en && addr == 8'h08;
  assign wr_c1  = wr_en && addr == 8'h09;
  assign wr_cyc = wr_en && (addr == 8'h04 || addr == 8'h05);

  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c0 |=> cnt_q[0] == $past(wdata));

  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && !wr_en) |=> ($stable(cnt_q) && $stable(cyc_q)));

  p_chain_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q[1] == 8'h1E && en_q[1] && inc[0] && (&cnt_q[0]) && !wr_c0 && !wr_c1)
    |=> cnt_q[1] == $past(cnt_q[1]) + 32'd1);

  p_chain_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[1] && !wr_c1) |=> $stable(cnt_q[1]));

  p_chain_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q[1] == 8'h1E && !en_q[0] && !wr_c1) |=> $stable(cnt_q[1]));

  p_cyc_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_inc && (&cyc_q) && !wr_cyc) |=> (ovf_q[31] && cyc_q == 64'd0));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q[0] && !(wr_en && addr == 8'h02 && wdata[0])) |=> ovf_q[0]);
endmodule

bind perf_counter_bank perf_counter_bank_chk #(.NCNT(NCNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .gen_en(gen_en), .en_q(en_q), .ovf_q(ovf_q), .cnt_q(cnt_q), .sel_q(sel_q),
  .cyc_q(cyc_q), .inc(inc), .cyc_inc(cyc_inc)
);

// File: tb/sim_perf_counter_bank.sv
module sim_perf_counter_bank;
  logic        clk = 0, rst_n = 0, wr_en = 0, cyc_tick = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [15:0] evt_in = 0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0, fails = 0, cycles = 0;

  perf_counter_bank #(.NCNT(4), .NEVT(16)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt_in(evt_in), .cyc_tick(cyc_tick), .irq(irq));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; total++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  typedef struct packed {
    logic [7:0]  code;
    logic [15:0] evt;
    logic [7:0]  pulses;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'h03, 16'h0008, 8'd5, 32'd5},
    '{8'h03, 16'h0004, 8'd5, 32'd0},
    '{8'h00, 16'hFFFF, 8'd7, 32'd7},
    '{8'h0F, 16'h8000, 8'd2, 32'd2},
    '{8'h20, 16'hFFFF, 8'd4, 32'd0},
    '{8'h1E, 16'hFFFF, 8'd3, 32'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input logic [15:0] e, input int n);
    @(negedge clk);
    evt_in = e;
    repeat (n) @(negedge clk);
    evt_in = 0;
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(8'(a), v); chk("R1", v, 0);
    end
    rd(8'h08, v); chk("R1", v, 0);
    rd(8'h11, v); chk("R1", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2/R5 table walk on counter 0
    wr(8'h00, 1);
    wr(8'h01, 1);
    for (int k = 0; k < 6; k++) begin
      wr(8'h08, 0);
      wr(8'h10, {24'b0, VECS[k].code});
      pulse(VECS[k].evt, int'(VECS[k].pulses));
      rd(8'h08, v);
      chk(VECS[k].code == 8'h1E ? "R5 even link code" : "R2", v, VECS[k].exp);
    end

    // R3 chain pair 0/1
    wr(8'h10, 8'h00);
    wr(8'h11, 8'h1E);
    wr(8'h08, 32'hFFFF_FFFE);
    wr(8'h09, 32'd5);
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h01, 32'h3);
    pulse(16'h0001, 3);
    rd(8'h08, v); chk("R3 low", v, 32'd1);
    rd(8'h09, v); chk("R3 high", v, 32'd6);
    rd(8'h02, v); chk("R8 set", v & 32'h3, 32'h1);

    // R4 odd disabled ignores wrap
    wr(8'h01, 32'h1);
    wr(8'h08, 32'hFFFF_FFFF);
    pulse(16'h0001, 1);
    rd(8'h08, v); chk("R4 low", v, 0);
    rd(8'h09, v); chk("R4 high", v, 32'd6);

    // R5 even disabled
    wr(8'h01, 32'h2);
    wr(8'h08, 32'hFFFF_FFFF);
    pulse(16'h0001, 2);
    rd(8'h09, v); chk("R5 high", v, 32'd6);

    // R8 clear and set-wins
    wr(8'h02, 32'h1);
    rd(8'h02, v); chk("R8 clear", v, 0);
    wr(8'h01, 32'h1);
    wr(8'h08, 32'hFFFF_FFFF);
    @(negedge clk);
    wr_en = 1; addr = 8'h02; wdata = 32'h1; evt_in = 16'h0001;
    @(negedge clk);
    wr_en = 0; evt_in = 0;
    rd(8'h02, v); chk("R8 set wins", v, 32'h1);

    // R11 write beats increment
    @(negedge clk);
    wr_en = 1; addr = 8'h08; wdata = 32'd100; evt_in = 16'h0001;
    @(negedge clk);
    wr_en = 0; evt_in = 0;
    rd(8'h08, v); chk("R11", v, 32'd100);

    // R6 cycle counter
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h04, 0);
    wr(8'h05, 0);
    wr(8'h01, 32'h8000_0000);
    @(negedge clk); cyc_tick = 1;
    repeat (10) @(negedge clk);
    cyc_tick = 0;
    rd(8'h04, v); chk("R6 low", v, 32'd10);
    wr(8'h04, 32'hFFFF_FFFF);
    @(negedge clk); cyc_tick = 1;
    @(negedge clk); cyc_tick = 0;
    rd(8'h05, v); chk("R6 carry", v, 32'd1);
    rd(8'h02, v); chk("R7 no ovf", v, 0);

    // R7 32-bit emulation via preload
    wr(8'h05, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFD);
    @(negedge clk); cyc_tick = 1;
    repeat (3) @(negedge clk);
    cyc_tick = 0;
    rd(8'h04, v); chk("R7 low", v, 0);
    rd(8'h02, v); chk("R7 flag", v, 32'h8000_0000);

    // R9 interrupt masking
    chk("R9 masked", {31'b0, irq}, 0);
    wr(8'h03, 32'h8000_0000);
    #1 chk("R9 unmasked", {31'b0, irq}, 1);
    wr(8'h02, 32'h8000_0000);
    #1 chk("R9 cleared", {31'b0, irq}, 0);

    // R10 global enable off
    wr(8'h01, 32'h8000_0001);
    wr(8'h00, 0);
    wr(8'h08, 32'd7);
    pulse(16'h0001, 4);
    @(negedge clk); cyc_tick = 1;
    @(negedge clk); cyc_tick = 0;
    rd(8'h08, v); chk("R10 hold", v, 32'd7);
    rd(8'h04, v); chk("R10 cyc hold", v, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule